// File: doc/BRIEF.md
# Fault Shutdown and Release Controller

This block decides what a motor-and-regulator power chip does when something goes wrong. It takes already-detected fault flags: over-temperature, motor over-current, and per-regulator over-current, under-voltage and over-voltage for three switching regulators and one linear regulator. It gates the enables of the regulators, the linear regulator and the motor bridges. It also drives an active-low system reset output towards the host.

Each fault class follows a policy chosen by configuration inputs. The thermal policy is a 2-bit code and the motor over-current policy is a single bit. A fault can latch everything off and hold the reset output low. It can instead stop only the motors and leave the supplies up, either keeping the reset output high or emitting one timed reset pulse. Per-regulator selective masks decide whether a regulator fault stops only that regulator or the whole chip. A hard latch-off clears only when the supply-low flag is raised or the reset pin is pulled low. Softer shutdowns also clear on a low-to-high transition of the sleep pin.

Fault flags are captured in sticky latches, so a flag lasting a single clock still applies its policy. A 4-bit select picks which latched fault class, or which fixed identification bit, appears on the status output.

Top module: `fault_guard`

## Requirements
- R1: After reset with no fault, each of regEn, ldoEn and motorEn equals its request input, and rstOutN is 1.
- R2: A thermal fault with tsdCtl equal to 00 or 11 turns off all regulators, the linear regulator and the motors, and holds rstOutN at 0. A later sleepN rise does not release this state.
- R3: A thermal fault with tsdCtl equal to 01 turns off only the motors and keeps rstOutN at 1. A sleepN 0-to-1 transition then restores the motor enable.
- R4: A thermal fault with tsdCtl equal to 10 behaves as in R3, except that rstOutN goes low for one reset pulse.
- R5: A motor over-current with misdCtl equal to 0 turns off only the motors, emits one reset pulse, and is released by a sleepN rise. With misdCtl equal to 1 it shuts everything off like R2, and a sleepN rise does not release it.
- R6: A reset pulse keeps rstOutN low for exactly CLK_HZ/1000*PULSE_MS clock cycles, starting from the clock edge that samples the fault.
- R7: While supplyLow is 1, all enables and rstOutN are 0. The first edge with supplyLow high, or rstN low, clears every latched shutdown and fault flag.
- R8: selMask bits 0, 1 and 2 belong to regulators A, B and C, and bit 3 to the linear regulator. A fault on a masked unit turns off only that unit until a sleepN rise. A fault on an unmasked unit shuts everything off like R2.
- R9: statusOut by statusSel: 0,1,2 = 0 if regulator A/B/C has a latched fault; 3 = 0 on any latched over-current of a regulator or on a linear regulator fault; 4 = 0 on any latched under-voltage; 5 = 0 on any latched over-voltage; 6 = 0 on motor over-current; 7 = 0 on thermal fault; 8,9,10 = REV_CODE bits 0,1,2; 11,12 = DEV_CODE bits 0,1; 14 = 0 on linear regulator fault; 13 and 15 = 1.
- R10: A fault input high for a single clock cycle applies its full policy, and its status flag stays latched until released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Reset pin, active low, asynchronous |
| sleepN | input | 1 | Sleep pin; its rise releases soft shutdowns |
| supplyLow | input | 1 | Supply below operating threshold |
| thermFault | input | 1 | Over-temperature flag |
| motorOc | input | 1 | Motor over-current flag |
| regOcp | input | 3 | Over-current flags, regulators A..C |
| regUvp | input | 3 | Under-voltage flags, regulators A..C |
| regOvp | input | 3 | Over-voltage flags, regulators A..C |
| ldoFault | input | 1 | Linear regulator fault flag |
| tsdCtl | input | 2 | Thermal fault policy |
| misdCtl | input | 1 | Motor over-current policy |
| selMask | input | 4 | Selective shutdown masks (A, B, C, linear) |
| regReq | input | 3 | Requested regulator enables |
| ldoReq | input | 1 | Requested linear regulator enable |
| motorReq | input | 1 | Requested motor enable |
| statusSel | input | 4 | Status output select |
| regEn | output | 3 | Regulator enables |
| ldoEn | output | 1 | Linear regulator enable |
| motorEn | output | 1 | Motor bridge enable |
| rstOutN | output | 1 | System reset output, active low |
| statusOut | output | 1 | Selected status bit |

## Verification
The assertions assume that tsdCtl, misdCtl and selMask do not change in the same cycle that a fault is raised. They also assume that supplyLow and sleepN are already synchronous to clk. The bench changes every input only on the falling clock edge. It sets the policy inputs several cycles before it fires a fault, and it raises each fault for one cycle so that the latch path carries the policy. It separates sleep transitions from fault pulses by at least one full cycle, so a release and a new fault never meet on the same edge.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam int NREG = 3;

  typedef struct packed {
    logic [NREG-1:0] ocp;
    logic [NREG-1:0] uvp;
    logic [NREG-1:0] ovp;
    logic            ldo;
    logic            motor;
    logic            therm;
  } fg_faults_t;

  typedef struct packed {
    logic clrFlags;
    logic acceptRaw;
    logic pulseGo;
    logic pulseKill;
  } fg_strobe_t;
endpackage

// File: rtl/fg_data.sv
module fg_data
  import fg_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned PULSE_MS = 40,
  parameter logic [2:0]  REV_CODE = 3'b001,
  parameter logic [1:0]  DEV_CODE = 2'b01
) (
  input  logic       clk,
  input  logic       rstN,
  input  fg_faults_t raw,
  input  fg_strobe_t stb,
  input  logic [3:0] statusSel,
  output fg_faults_t flags,
  output logic       pulseBusy,
  output logic       statusOut
);
  localparam int unsigned PULSE_LEN = (CLK_HZ / 1000) * PULSE_MS;
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
      cnt   <= '0;
    end else begin
      flags <= (stb.clrFlags ? '0 : flags) | (stb.acceptRaw ? raw : '0);
      if (stb.pulseKill)         cnt <= '0;
      else if (stb.pulseGo)      cnt <= CW'(PULSE_LEN);
      else if (cnt != '0)        cnt <= cnt - 1'b1;
    end
  end

  assign pulseBusy = (cnt != '0);

  logic [NREG-1:0] regAny;
  always_comb begin
    for (int i = 0; i < NREG; i++)
      regAny[i] = flags.ocp[i] | flags.uvp[i] | flags.ovp[i];
  end

  always_comb begin
    case (statusSel)
      4'd0:    statusOut = ~regAny[0];
      4'd1:    statusOut = ~regAny[1];
      4'd2:    statusOut = ~regAny[2];
      4'd3:    statusOut = ~((|flags.ocp) | flags.ldo);
      4'd4:    statusOut = ~(|flags.uvp);
      4'd5:    statusOut = ~(|flags.ovp);
      4'd6:    statusOut = ~flags.motor;
      4'd7:    statusOut = ~flags.therm;
      4'd8:    statusOut = REV_CODE[0];
      4'd9:    statusOut = REV_CODE[1];
      4'd10:   statusOut = REV_CODE[2];
      4'd11:   statusOut = DEV_CODE[0];
      4'd12:   statusOut = DEV_CODE[1];
      4'd14:   statusOut = ~flags.ldo;
      default: statusOut = 1'b1;
    endcase
  end

  // R4
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.pulseGo && !stb.pulseKill |=> pulseBusy);

  // R6
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt == CW'(1) && !stb.pulseGo && !stb.pulseKill |=> !pulseBusy);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags.therm && !stb.clrFlags |=> flags.therm);
endmodule

// File: rtl/fg_ctrl.sv
module fg_ctrl
  import fg_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            sleepN,
  input  logic            supplyLow,
  input  fg_faults_t      raw,
  input  fg_faults_t      flags,
  input  logic            pulseBusy,
  input  logic [1:0]      tsdCtl,
  input  logic            misdCtl,
  input  logic [NREG:0]   selMask,
  input  logic [NREG-1:0] regReq,
  input  logic            ldoReq,
  input  logic            motorReq,
  output fg_strobe_t      stb,
  output logic [NREG-1:0] regEn,
  output logic            ldoEn,
  output logic            motorEn,
  output logic            rstOutN
);
  logic            sleepPrev, hardOff, motorOff, ldoOff;
  logic [NREG-1:0] regOff, regRaw;
  logic            live, sleepRise, relOk;
  logic            thermHard, thermSoft, motHard, motSoft, regHard, anyHard;

  always_comb begin
    for (int i = 0; i < NREG; i++)
      regRaw[i] = raw.ocp[i] | raw.uvp[i] | raw.ovp[i];
  end

  assign live      = !supplyLow;
  assign thermHard = raw.therm && (tsdCtl == 2'b00 || tsdCtl == 2'b11);
  assign thermSoft = raw.therm && !thermHard;
  assign motHard   = raw.motor && misdCtl;
  assign motSoft   = raw.motor && !misdCtl;
  assign regHard   = (|(regRaw & ~selMask[NREG-1:0])) || (raw.ldo && !selMask[NREG]);
  assign anyHard   = thermHard || motHard || regHard;
  assign sleepRise = sleepN && !sleepPrev;
  assign relOk     = sleepRise && !hardOff;

  always_comb begin
    stb.pulseKill = supplyLow;
    stb.acceptRaw = live;
    stb.clrFlags  = supplyLow || relOk;
    stb.pulseGo   = live &&
                    ((raw.therm && !flags.therm && tsdCtl == 2'b10) ||
                     (raw.motor && !flags.motor && !misdCtl));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepPrev <= 1'b1;
      hardOff   <= 1'b0;
      motorOff  <= 1'b0;
      ldoOff    <= 1'b0;
      regOff    <= '0;
    end else begin
      sleepPrev <= sleepN;
      if (supplyLow) begin
        hardOff  <= 1'b0;
        motorOff <= 1'b0;
        ldoOff   <= 1'b0;
        regOff   <= '0;
      end else begin
        hardOff  <= hardOff | anyHard;
        motorOff <= (motorOff & ~relOk) | thermSoft | motSoft;
        ldoOff   <= (ldoOff & ~relOk) | (raw.ldo & selMask[NREG]);
        regOff   <= (regOff & ~{NREG{relOk}}) | (regRaw & selMask[NREG-1:0]);
      end
    end
  end

  logic shutAll;
  assign shutAll = hardOff || supplyLow;
  assign regEn   = regReq & ~regOff & ~{NREG{shutAll}};
  assign ldoEn   = ldoReq && !ldoOff && !shutAll;
  assign motorEn = motorReq && !motorOff && !shutAll;
  assign rstOutN = !(shutAll || pulseBusy);

  // R2
  hard_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    hardOff && !supplyLow |=> hardOff);

  // R7
  supply_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |=> !hardOff && !motorOff && !ldoOff && regOff == '0);

  // R3
  soft_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    relOk && !raw.therm && !raw.motor && regRaw == '0 && !raw.ldo
      |=> !motorOff && !ldoOff && regOff == '0);

  // R5
  motor_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (motorOff || hardOff) |-> !motorEn);
endmodule

// File: rtl/fault_guard.sv
module fault_guard
  import fg_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned PULSE_MS = 40,
  parameter logic [2:0]  REV_CODE = 3'b001,
  parameter logic [1:0]  DEV_CODE = 2'b01
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sleepN,
  input  logic            supplyLow,
  input  logic            thermFault,
  input  logic            motorOc,
  input  logic [NREG-1:0] regOcp,
  input  logic [NREG-1:0] regUvp,
  input  logic [NREG-1:0] regOvp,
  input  logic            ldoFault,
  input  logic [1:0]      tsdCtl,
  input  logic            misdCtl,
  input  logic [NREG:0]   selMask,
  input  logic [NREG-1:0] regReq,
  input  logic            ldoReq,
  input  logic            motorReq,
  input  logic [3:0]      statusSel,
  output logic [NREG-1:0] regEn,
  output logic            ldoEn,
  output logic            motorEn,
  output logic            rstOutN,
  output logic            statusOut
);
  fg_faults_t raw, flags;
  fg_strobe_t stb;
  logic       pulseBusy;

  assign raw = '{ocp: regOcp, uvp: regUvp, ovp: regOvp,
                 ldo: ldoFault, motor: motorOc, therm: thermFault};

  fg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sleepN(sleepN), .supplyLow(supplyLow),
    .raw(raw), .flags(flags), .pulseBusy(pulseBusy),
    .tsdCtl(tsdCtl), .misdCtl(misdCtl), .selMask(selMask),
    .regReq(regReq), .ldoReq(ldoReq), .motorReq(motorReq),
    .stb(stb), .regEn(regEn), .ldoEn(ldoEn), .motorEn(motorEn),
    .rstOutN(rstOutN)
  );

  fg_data #(.CLK_HZ(CLK_HZ), .PULSE_MS(PULSE_MS),
            .REV_CODE(REV_CODE), .DEV_CODE(DEV_CODE)) u_data (
    .clk(clk), .rstN(rstN), .raw(raw), .stb(stb), .statusSel(statusSel),
    .flags(flags), .pulseBusy(pulseBusy), .statusOut(statusOut)
  );
endmodule

// File: tb/fault_guard_tb.sv
module fault_guard_tb;
  logic clk = 0;
  logic rstN = 0, sleepN = 1, supplyLow = 0, thermFault = 0, motorOc = 0, ldoFault = 0;
  logic [2:0] regOcp = 0, regUvp = 0, regOvp = 0, regReq = 3'b111;
  logic [1:0] tsdCtl = 0;
  logic misdCtl = 0, ldoReq = 1, motorReq = 1;
  logic [3:0] selMask = 0, statusSel = 0;
  logic [2:0] regEn;
  logic ldoEn, motorEn, rstOutN, statusOut;

  always #10 clk = ~clk;

  fault_guard #(.CLK_HZ(1000), .PULSE_MS(40), .REV_CODE(3'b101), .DEV_CODE(2'b10)) u_dut (
    .clk(clk), .rstN(rstN), .sleepN(sleepN), .supplyLow(supplyLow),
    .thermFault(thermFault), .motorOc(motorOc), .regOcp(regOcp), .regUvp(regUvp),
    .regOvp(regOvp), .ldoFault(ldoFault), .tsdCtl(tsdCtl), .misdCtl(misdCtl),
    .selMask(selMask), .regReq(regReq), .ldoReq(ldoReq), .motorReq(motorReq),
    .statusSel(statusSel), .regEn(regEn), .ldoEn(ldoEn), .motorEn(motorEn),
    .rstOutN(rstOutN), .statusOut(statusOut)
  );

  typedef struct {
    string      tag;
    logic [5:0] outs;
    logic       useStat;
    logic       stat;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      wait (q.size() != 0);
      begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (it.useStat) begin
          if (statusOut !== it.stat) begin
            errors++;
            $display("FAIL %s statusOut actual=%b expected=%b", it.tag, statusOut, it.stat);
          end
        end else if ({regEn, ldoEn, motorEn, rstOutN} !== it.outs) begin
          errors++;
          $display("FAIL %s outs actual=%b expected=%b", it.tag,
                   {regEn, ldoEn, motorEn, rstOutN}, it.outs);
        end
      end
    end
  end

  task automatic push_item(input string tag, input logic [5:0] outs,
                           input logic useStat, input logic stat);
    item_t it;
    it.tag = tag; it.outs = outs; it.useStat = useStat; it.stat = stat;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic chk_out(input string tag, input logic [5:0] outs);
    push_item(tag, outs, 1'b0, 1'b0);
  endtask

  task automatic chk_stat(input string tag, input logic [3:0] sel, input logic v);
    statusSel = sel;
    #1;
    push_item(tag, 6'b0, 1'b1, v);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sleep_cycle();
    sleepN = 0; tick(2); sleepN = 1; tick(1);
  endtask

  task automatic supply_cycle();
    supplyLow = 1; #1;
    chk_out("R7 outputs forced off while supply low", 6'b000000);
    tick(1); supplyLow = 0; tick(1);
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(2); rstN = 1; tick(2);
    chk_out("R1 reset state", 6'b111111);
    chk_stat("R1 status idle sel7", 4'd7, 1'b1);

    // R2 thermal latch-off, not released by sleep, released by supply low
    tsdCtl = 2'b00; tick(2);
    thermFault = 1; tick(1); thermFault = 0;
    chk_out("R2 tsd00 all off", 6'b000000);
    chk_stat("R10 thermal flag latched", 4'd7, 1'b0);
    sleep_cycle();
    chk_out("R2 sleep rise ignored", 6'b000000);
    supply_cycle();
    chk_out("R7 release by supply low", 6'b111111);
    chk_stat("R7 flags cleared", 4'd7, 1'b1);

    tsdCtl = 2'b11; tick(2);
    thermFault = 1; tick(1); thermFault = 0;
    chk_out("R2 tsd11 all off", 6'b000000);
    supply_cycle();

    // R3 motors only
    tsdCtl = 2'b01; tick(2);
    thermFault = 1; tick(1); thermFault = 0;
    chk_out("R3 tsd01 motor off reset high", 6'b111101);
    tick(5);
    chk_out("R3 state held", 6'b111101);
    sleep_cycle();
    chk_out("R3 sleep rise release", 6'b111111);

    // R4/R6 pulse
    tsdCtl = 2'b10; tick(2);
    thermFault = 1; tick(1); thermFault = 0;
    chk_out("R4 tsd10 pulse start", 6'b111100);
    tick(39);
    chk_out("R6 pulse still low at last cycle", 6'b111100);
    tick(1);
    chk_out("R6 pulse ends", 6'b111101);
    sleep_cycle();
    chk_out("R4 sleep rise release", 6'b111111);

    // R5 motor over-current
    tsdCtl = 2'b00; misdCtl = 0; tick(2);
    motorOc = 1; tick(1); motorOc = 0;
    chk_out("R5 misd0 pulse", 6'b111100);
    chk_stat("R9 motor flag sel6", 4'd6, 1'b0);
    tick(40);
    chk_out("R5 misd0 after pulse", 6'b111101);
    sleep_cycle();
    chk_out("R5 misd0 release", 6'b111111);

    misdCtl = 1; tick(2);
    motorOc = 1; tick(1); motorOc = 0;
    chk_out("R5 misd1 all off", 6'b000000);
    sleep_cycle();
    chk_out("R5 misd1 sleep ignored", 6'b000000);
    rstN = 0; tick(1); rstN = 1; tick(1);
    chk_out("R7 release by reset pin", 6'b111111);
    misdCtl = 0;

    // R8 masked regulator B
    selMask = 4'b0010; tick(2);
    regOvp = 3'b010; tick(1); regOvp = 0;
    chk_out("R8 masked B only off", 6'b101111);
    chk_stat("R9 sel1 reg B", 4'd1, 1'b0);
    chk_stat("R9 sel5 ovp", 4'd5, 1'b1 ^ 1'b1);
    chk_stat("R9 sel0 reg A clean", 4'd0, 1'b1);
    sleep_cycle();
    chk_out("R8 masked release", 6'b111111);

    // R8 unmasked regulator A
    regUvp = 3'b001; tick(1); regUvp = 0;
    chk_out("R8 unmasked A all off", 6'b000000);
    chk_stat("R9 sel4 uvp", 4'd4, 1'b0);
    chk_stat("R9 sel3 no ocp", 4'd3, 1'b1);
    chk_stat("R9 sel8 rev0", 4'd8, 1'b1);
    chk_stat("R9 sel9 rev1", 4'd9, 1'b0);
    chk_stat("R9 sel10 rev2", 4'd10, 1'b1);
    chk_stat("R9 sel11 dev0", 4'd11, 1'b0);
    chk_stat("R9 sel12 dev1", 4'd12, 1'b1);
    chk_stat("R9 sel15 fixed", 4'd15, 1'b1);
    supply_cycle();

    // R8 masked linear regulator
    selMask = 4'b1000; tick(2);
    ldoFault = 1; tick(1); ldoFault = 0;
    chk_out("R8 masked linear off", 6'b111011);
    chk_stat("R9 sel14 linear", 4'd14, 1'b0);
    chk_stat("R9 sel3 linear", 4'd3, 1'b0);
    sleep_cycle();
    chk_out("R8 linear release", 6'b111111);

    tick(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule